// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a watchdog timer that runs on its own slow clock. A 12-bit counter counts down once every prescaled period. Software must refresh it by writing a refresh key before the count runs out. If it does not, the block emits a reset request. Control goes through a small write-only register port at four addresses: a key register, a prescaler code, a reload value and a window value. Key writes start the watchdog, unlock the three configuration registers, or refresh the counter. Once started, the watchdog cannot be stopped by any write. A strap input can also start it directly.

An optional window catches a misbehaving loop that refreshes too often. If the window value is below the full-scale count and a refresh arrives while the count is still above it, the block requests a reset instead of granting the refresh.

A configuration write does not take effect at once. It passes through a short transfer stage, and a per-register busy flag stays set until the new value is in use. Applying a new window value also reloads the counter. While a debug freeze is requested and the core is halted, the countdown pauses.

Top module: `kwd_watchdog`

## Requirements
- R1: After reset the count is 0xFFF, the watchdog is not running, all busy flags and the reset request are 0, the prescaler code is 0, and both reload and window hold 0xFFF. With the window at 0xFFF, no refresh causes a reset request.
- R2: A write of 0xCCCC to address 0 (the key register), or a high strap input at any clock, sets the watchdog running. Only reset clears running. While the watchdog is idle the count does not move.
- R3: While running and not frozen, the count drops by one every 4·2^c clocks. Here c is the prescaler code written to bits [2:0] of address 1, and codes above 6 act as 6 (divide by 256).
- R4: When a decrement is due while the count is 0, the block raises the reset request for exactly one clock. In the same clock it loads the reload value into the counter, and counting carries on.
- R5: A write of 0xAAAA to the key register loads the reload value (address 2, bits [11:0]) into the counter and restarts the prescaler phase.
- R6: A write of 0x5555 to the key register unlocks addresses 1 to 3. Any key value other than 0x5555, 0xAAAA or 0xCCCC locks them again. A write to a locked register is ignored: its busy flag stays 0 and its value is unchanged.
- R7: An accepted configuration write sets its busy flag (bit 0 prescaler, bit 1 reload, bit 2 window) for SYNC_STAGES clocks. The new value then takes effect and the flag clears.
- R8: When a new window value (address 3, bits [11:0]) takes effect, the counter is reloaded from the reload value.
- R9: A refresh while running, with the window below 0xFFF and the count above the window, produces a one-clock reset request and a reload. A refresh with the count at or below the window only reloads.
- R10: While both the debug-freeze input and the core-halted input are high, the count and the prescaler phase hold. Either input alone has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_start | input | 1 | Hardware start strap |
| dbg_freeze | input | 1 | Debug freeze request |
| core_halted | input | 1 | Core halted indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 key, 1 prescaler, 2 reload, 3 window |
| wr_data | input | 16 | Write data |
| running | output | 1 | Watchdog started |
| busy | output | 3 | Update pending flags {window, reload, prescaler} |
| count | output | 12 | Current counter value |
| rst_req | output | 1 | One-clock reset request |

## Verification
The hardest situation to reach is the early-refresh violation. It needs the window lowered while the count sits above it, so the window update has to get through the unlock key and the transfer delay, and that update reloads the counter on its own. The stimulus first lets the count fall, then applies a window of 8, which pushes the count back to the reload value of 0x010. It then refreshes at once, while the count is still above the window. A refresh sent after the count has fallen to the window value shows the other side of the boundary. Relocking and then refreshing early again shows that a blocked window write left the old window in place.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   localparam int KEY_W = 16;
   localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
   localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
   localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;

   typedef enum logic [1:0] {
      SEL_KEY    = 2'd0,
      SEL_PRESC  = 2'd1,
      SEL_RELOAD = 2'd2,
      SEL_WINDOW = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/kwd_cfg_slot.sv
// One configuration register with a transfer stage into the counting logic.
module kwd_cfg_slot #(
   parameter int W = 8,
   parameter logic [W-1:0] RST_VAL = '0,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] value,
   output logic         busy,
   output logic         apply
);
   if (STAGES == 0) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    value <= RST_VAL;
         else if (load) value <= din;
      end
      assign busy  = 1'b0;
      assign apply = load;
   end else begin : g_staged
      localparam int TW = $clog2(STAGES + 1);
      logic [TW-1:0] tmr;
      logic [W-1:0]  pend;

      assign busy  = (tmr != '0);
      assign apply = (tmr == TW'(1)) && !load;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tmr   <= '0;
            pend  <= RST_VAL;
            value <= RST_VAL;
         end else if (load) begin
            pend <= din;
            tmr  <= TW'(STAGES);
         end else if (tmr != '0) begin
            tmr <= tmr - TW'(1);
            if (tmr == TW'(1)) value <= pend;
         end
      end
   end
endmodule

// File: rtl/kwd_prescaler.sv
// Power-of-two clock divider: one tick every 4 << code enabled clocks.
module kwd_prescaler #(
   parameter int PRE_W    = 3,
   parameter int MAX_CODE = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic [PRE_W-1:0] code,
   output logic             tick
);
   localparam int DIV_W = MAX_CODE + 2;

   logic [DIV_W:0]   phase;
   logic [DIV_W:0]   span;
   logic [PRE_W-1:0] code_c;

   assign code_c = (int'(code) > MAX_CODE) ? PRE_W'(MAX_CODE) : code;
   assign span   = (DIV_W + 1)'(4) << code_c;
   assign tick   = en && (phase == span - (DIV_W + 1)'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     phase <= '0;
      else if (clr)   phase <= '0;
      else if (tick)  phase <= '0;
      else if (en)    phase <= phase + (DIV_W + 1)'(1);
   end
endmodule

// File: rtl/kwd_watchdog.sv
module kwd_watchdog
   import kwd_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int PRE_W       = 3,
   parameter int MAX_CODE    = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_start,
   input  logic             dbg_freeze,
   input  logic             core_halted,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [KEY_W-1:0] wr_data,
   output logic             running,
   output logic [2:0]       busy,
   output logic [CNT_W-1:0] count,
   output logic             rst_req
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 2 || CNT_W > KEY_W) begin : g_bad_cnt
      $error("kwd_watchdog: CNT_W out of range");
   end
   if (MAX_CODE >= (1 << PRE_W) || MAX_CODE < 0) begin : g_bad_code
      $error("kwd_watchdog: MAX_CODE does not fit PRE_W");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("kwd_watchdog: SYNC_STAGES negative");
   end

   logic             run_q, unlock_q, req_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PRE_W-1:0] pre_code;
   logic [CNT_W-1:0] reload_val, win_val;
   logic             pre_busy, rel_busy, win_busy;
   logic             unused_pre_apply, unused_rel_apply, win_apply;
   logic             key_wr, cfg_ok, is_start, is_unlock, is_refresh;
   logic             frozen, step_en, tick, early, expire, reload_now;

   assign key_wr     = wr_en && (reg_sel_e'(wr_addr) == SEL_KEY);
   assign cfg_ok     = wr_en && (reg_sel_e'(wr_addr) != SEL_KEY) && unlock_q;
   assign is_start   = key_wr && (wr_data == KEY_START);
   assign is_unlock  = key_wr && (wr_data == KEY_UNLOCK);
   assign is_refresh = key_wr && (wr_data == KEY_REFRESH);

   kwd_cfg_slot #(.W(PRE_W), .RST_VAL('0), .STAGES(SYNC_STAGES)) u_presc (
      .clk(clk), .rst_n(rst_n),
      .load(cfg_ok && reg_sel_e'(wr_addr) == SEL_PRESC),
      .din(wr_data[PRE_W-1:0]),
      .value(pre_code), .busy(pre_busy), .apply(unused_pre_apply));

   kwd_cfg_slot #(.W(CNT_W), .RST_VAL(CNT_MAX), .STAGES(SYNC_STAGES)) u_reload (
      .clk(clk), .rst_n(rst_n),
      .load(cfg_ok && reg_sel_e'(wr_addr) == SEL_RELOAD),
      .din(wr_data[CNT_W-1:0]),
      .value(reload_val), .busy(rel_busy), .apply(unused_rel_apply));

   kwd_cfg_slot #(.W(CNT_W), .RST_VAL(CNT_MAX), .STAGES(SYNC_STAGES)) u_window (
      .clk(clk), .rst_n(rst_n),
      .load(cfg_ok && reg_sel_e'(wr_addr) == SEL_WINDOW),
      .din(wr_data[CNT_W-1:0]),
      .value(win_val), .busy(win_busy), .apply(win_apply));

   assign frozen  = dbg_freeze && core_halted;
   assign step_en = run_q && !frozen;

   kwd_prescaler #(.PRE_W(PRE_W), .MAX_CODE(MAX_CODE)) u_div (
      .clk(clk), .rst_n(rst_n), .en(step_en), .clr(reload_now),
      .code(pre_code), .tick(tick));

   assign early      = is_refresh && run_q && (win_val != CNT_MAX) && (cnt_q > win_val);
   assign expire     = tick && (cnt_q == '0);
   assign reload_now = is_refresh || win_apply || expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         unlock_q <= 1'b0;
         req_q    <= 1'b0;
         cnt_q    <= CNT_MAX;
      end else begin
         if (is_start || strap_start) run_q <= 1'b1;
         if (is_unlock)                        unlock_q <= 1'b1;
         else if (key_wr && !is_start && !is_refresh) unlock_q <= 1'b0;
         req_q <= expire || early;
         if (reload_now)  cnt_q <= reload_val;
         else if (tick)   cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign running = run_q;
   assign busy    = {win_busy, rel_busy, pre_busy};
   assign count   = cnt_q;
   assign rst_req = req_q;
endmodule

// File: rtl/kwd_watchdog_chk.sv
module kwd_watchdog_chk #(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             strap_start,
   input logic             dbg_freeze,
   input logic             core_halted,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic             running,
   input logic [2:0]       busy,
   input logic [CNT_W-1:0] count,
   input logic             rst_req
);
   logic key_wr;
   assign key_wr = wr_en && (wr_addr == 2'd0);

   // R2: running is sticky
   p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> running);

   // R2: idle counter does not move
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !key_wr && !busy[2]) |=> $stable(count));

   // R4 / R9: no reset request without a running watchdog
   p_idle_noreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !strap_start) |=> !rst_req);

   // R3: count moves by at most one step unless reloaded
   p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !key_wr && !busy[2]) |=>
         (count == $past(count) || count == $past(count) - CNT_W'(1) || rst_req));

   // R10: frozen counter holds
   p_freeze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_freeze && core_halted && !key_wr && !busy[2]) |=> $stable(count));

   // R7: a busy flag only rises after a write to its address
   p_busy_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[0]) |-> $past(wr_en && wr_addr == 2'd1));
   p_busy_rel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[1]) |-> $past(wr_en && wr_addr == 2'd2));
   p_busy_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[2]) |-> $past(wr_en && wr_addr == 2'd3));
endmodule

bind kwd_watchdog kwd_watchdog_chk #(.CNT_W(CNT_W)) u_kwd_chk (
   .clk(clk), .rst_n(rst_n), .strap_start(strap_start),
   .dbg_freeze(dbg_freeze), .core_halted(core_halted),
   .wr_en(wr_en), .wr_addr(wr_addr), .running(running),
   .busy(busy), .count(count), .rst_req(rst_req));

// File: tb/tb_kwd_watchdog.sv
module tb_kwd_watchdog;
   localparam int CLK_PERIOD = 10;
   localparam int STAGES     = 2;
   localparam int WD_LIMIT   = 50000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_start = 1'b0, dbg_freeze = 1'b0, core_halted = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        running, rst_req;
   logic [2:0]  busy;
   logic [11:0] count;

   int errors = 0, checks = 0, cyc = 0;
   bit cmp_on = 1'b0;
   string cur_req = "R1";

   kwd_watchdog #(.SYNC_STAGES(STAGES)) dut (
      .clk(clk), .rst_n(rst_n), .strap_start(strap_start),
      .dbg_freeze(dbg_freeze), .core_halted(core_halted),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .running(running), .busy(busy), .count(count), .rst_req(rst_req));

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   int m_cnt = 4095, m_phase = 0, m_run = 0, m_unl = 0, m_req = 0;
   int m_val[3] = '{0, 4095, 4095};
   int m_pend[3] = '{0, 4095, 4095};
   int m_tmr[3] = '{0, 0, 0};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 4095; m_phase = 0; m_run = 0; m_unl = 0; m_req = 0;
         m_val = '{0, 4095, 4095}; m_pend = '{0, 4095, 4095}; m_tmr = '{0, 0, 0};
      end else begin
         bit kw, cfg, refresh, step, viol, expire, reload, win_now;
         int lim, pc;
         kw      = wr_en && wr_addr == 2'd0;
         cfg     = wr_en && wr_addr != 2'd0 && m_unl == 1;
         refresh = kw && wr_data == 16'hAAAA;
         win_now = m_tmr[2] == 1 && !(cfg && wr_addr == 2'd3);
         pc      = (m_val[0] > 6) ? 6 : m_val[0];
         lim     = 4 << pc;
         step    = m_run == 1 && !(dbg_freeze && core_halted) && m_phase == lim - 1;
         viol    = refresh && m_run == 1 && m_val[2] != 4095 && m_cnt > m_val[2];
         expire  = step && m_cnt == 0;
         reload  = refresh || win_now || expire;
         m_req   = (expire || viol) ? 1 : 0;
         if (reload) begin m_cnt = m_val[1]; m_phase = 0; end
         else if (m_run == 1 && !(dbg_freeze && core_halted)) begin
            if (step) begin m_cnt = m_cnt - 1; m_phase = 0; end
            else m_phase = m_phase + 1;
         end
         for (int i = 0; i < 3; i++) begin
            if (cfg && int'(wr_addr) == i + 1) begin
               m_pend[i] = (i == 0) ? int'(wr_data[2:0]) : int'(wr_data[11:0]);
               m_tmr[i]  = STAGES;
            end else if (m_tmr[i] > 0) begin
               if (m_tmr[i] == 1) m_val[i] = m_pend[i];
               m_tmr[i] = m_tmr[i] - 1;
            end
         end
         if ((kw && wr_data == 16'hCCCC) || strap_start) m_run = 1;
         if (kw) begin
            if (wr_data == 16'h5555) m_unl = 1;
            else if (wr_data != 16'hAAAA && wr_data != 16'hCCCC) m_unl = 0;
         end
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         int mb;
         mb = ((m_tmr[2] > 0) ? 4 : 0) | ((m_tmr[1] > 0) ? 2 : 0) | ((m_tmr[0] > 0) ? 1 : 0);
         check(cur_req, "model count",   int'(count),   m_cnt);
         check(cur_req, "model running", int'(running), m_run);
         check(cur_req, "model busy",    int'(busy),    mb);
         check(cur_req, "model rst_req", int'(rst_req), m_req);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WD_LIMIT);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      int c0;
      idle(3);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      idle(1);
      // R1 reset state
      check("R1", "count", int'(count), 12'hFFF);
      check("R1", "running", int'(running), 0);
      check("R1", "busy", int'(busy), 0);
      check("R1", "rst_req", int'(rst_req), 0);
      cur_req = "R2";
      idle(5);
      check("R2", "idle count", int'(count), 12'hFFF);

      cur_req = "R6";
      wr(2'd2, 16'h0010);
      check("R6", "locked write busy", int'(busy), 0);

      cur_req = "R7";
      wr(2'd0, 16'h5555);
      wr(2'd2, 16'h0010);
      check("R7", "busy after write", int'(busy), 3'b010);
      idle(1);
      check("R7", "busy mid transfer", int'(busy), 3'b010);
      idle(1);
      check("R7", "busy cleared", int'(busy), 0);

      cur_req = "R2";
      wr(2'd0, 16'hCCCC);
      check("R2", "start key", int'(running), 1);
      cur_req = "R5";
      wr(2'd0, 16'hAAAA);
      check("R5", "refresh loads reload", int'(count), 12'h010);
      cur_req = "R3";
      idle(3);
      check("R3", "div4 before step", int'(count), 12'h010);
      idle(1);
      check("R3", "div4 step", int'(count), 12'h00F);

      cur_req = "R4";
      for (int i = 0; i < 200 && !rst_req; i++) @(negedge clk);
      check("R4", "expiry request", int'(rst_req), 1);
      check("R4", "reload on expiry", int'(count), 12'h010);
      idle(1);
      check("R4", "single pulse", int'(rst_req), 0);

      cur_req = "R3";
      wr(2'd1, 16'h0002);
      idle(2);
      wr(2'd0, 16'hAAAA);
      idle(15);
      check("R3", "div16 before step", int'(count), 12'h010);
      idle(1);
      check("R3", "div16 step", int'(count), 12'h00F);
      wr(2'd1, 16'h0007);
      idle(2);
      wr(2'd0, 16'hAAAA);
      idle(255);
      check("R3", "clamped before step", int'(count), 12'h010);
      idle(1);
      check("R3", "clamped step", int'(count), 12'h00F);
      wr(2'd1, 16'h0000);
      idle(2);

      cur_req = "R10";
      wr(2'd0, 16'hAAAA);
      dbg_freeze = 1'b1;
      idle(8);
      check("R10", "freeze alone ignored", int'(count), 12'h00E);
      core_halted = 1'b1;
      c0 = int'(count);
      idle(20);
      check("R10", "frozen hold", int'(count), c0);
      dbg_freeze = 1'b0;
      idle(8);
      check("R10", "halt alone ignored", int'(count), c0 - 2);
      core_halted = 1'b0;

      cur_req = "R8";
      wr(2'd0, 16'hAAAA);
      idle(8);
      wr(2'd3, 16'h0008);
      check("R8", "window busy", int'(busy), 3'b100);
      idle(1);
      check("R8", "count before apply", int'(count), 12'h00E);
      idle(1);
      check("R8", "window apply reload", int'(count), 12'h010);
      check("R8", "window busy clear", int'(busy), 0);

      cur_req = "R9";
      wr(2'd0, 16'hAAAA);
      check("R9", "early refresh request", int'(rst_req), 1);
      check("R9", "early refresh reload", int'(count), 12'h010);
      idle(1);
      check("R9", "early pulse ends", int'(rst_req), 0);
      idle(32);
      check("R9", "count at window", int'(count), 12'h008);
      wr(2'd0, 16'hAAAA);
      check("R9", "in-window refresh no request", int'(rst_req), 0);
      check("R9", "in-window refresh reload", int'(count), 12'h010);

      cur_req = "R6";
      wr(2'd0, 16'h1234);
      wr(2'd3, 16'h0020);
      check("R6", "relocked write busy", int'(busy), 0);
      wr(2'd0, 16'hAAAA);
      check("R6", "window kept after blocked write", int'(rst_req), 1);

      cur_req = "R2";
      cmp_on = 1'b0;
      strap_start = 1'b1;
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      cmp_on = 1'b1;
      check("R2", "strap start", int'(running), 1);
      strap_start = 1'b0;
      wr(2'd0, 16'h1234);
      check("R2", "cannot stop", int'(running), 1);
      cur_req = "R1";
      wr(2'd0, 16'hAAAA);
      check("R1", "default window no request", int'(rst_req), 0);
      check("R1", "default reload", int'(count), 12'hFFF);
      idle(4);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule